// File: doc/BRIEF.md
# Memory Refresh Scheduler

This block keeps a dynamic memory of `ROWS` rows (512 by default) alive. A free-running interval timer produces one refresh obligation every `floor(WINDOW_US × f_clk / ROWS) − MARGIN` clock cycles, so every row is visited within the retention window (8 ms by default). Obligations are held in a small saturating counter. While at least one is held and no refresh is in progress, the block raises a request to the memory access arbiter.

When the arbiter grants, the block drives one refresh cycle on the memory's strobes. In the default mode the column strobe goes low one cycle before the row strobe and no address is driven, because the memory steps its own internal row counter. When the mode input is high, the block instead runs a row-strobe-only cycle. In that mode it drives a row address taken from its own counter, which advances once per such cycle and wraps to zero after the last row. The data lines are never driven.

The clock frequency is a parameter (`CLK_KHZ`). The low time of the row strobe (`RAS_CYC`) and the recovery time (`PRE_CYC`) are parameters too, counted in cycles.

Top module: `rfsh_sched`

## Requirements
- R1: The first request rises `INTERVAL + 2` clock edges after reset release, where `INTERVAL = floor(WINDOW_US*CLK_KHZ/1000/ROWS) - MARGIN` and the extra two edges come from the reset synchronizer. Under continuous grant, successive row-strobe falls are exactly `INTERVAL` cycles apart.
- R2: `req_o` is high only while an obligation is held and no refresh cycle is running. While it is high, `ras_n_o` and `cas_n_o` are both 1 and `addr_oe_o` is 0.
- R3: In column-before-row mode (`row_mode_i` = 0 at grant), `cas_n_o` is 0 in the cycle before `ras_n_o` falls and stays 0 while `ras_n_o` is 0. `addr_oe_o` stays 0 throughout.
- R4: In row-only mode (`row_mode_i` = 1 at grant), `addr_oe_o` is 1 in the cycle before and during the row-strobe low time. `cas_n_o` stays 1, and `addr_o` holds a stable value while `ras_n_o` is 0.
- R5: The row-only address starts at 0 after reset and increases by one per row-only cycle, wrapping from `ROWS-1` (511) to 0. Column-before-row cycles leave it unchanged.
- R6: `dq_oe_o` is 0 at all times, so the data lines stay high-impedance.
- R7: At most `MAX_PEND` (default 4) obligations are held. Further timer events while the counter is full are dropped, and every held obligation is later issued as one refresh cycle.
- R8: No strobe activity starts without a grant. A cycle begins only on an edge where `req_o` and `gnt_i` are both 1.
- R9: The mode is sampled at the grant. A change of `row_mode_i` during a running cycle does not alter that cycle.
- R10: During reset `ras_n_o` and `cas_n_o` are 1, `req_o` and `addr_oe_o` are 0, and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_mode_i | input | 1 | 1 selects row-only refresh, 0 selects column-before-row |
| gnt_i | input | 1 | Grant from the access arbiter |
| req_o | output | 1 | Refresh request to the arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | $clog2(ROWS) | Row address for row-only refresh |
| addr_oe_o | output | 1 | Address output enable |
| dq_oe_o | output | 1 | Data line output enable, held low |

## Verification
The bench first runs with continuous grant in column-before-row mode. This checks the exact first-request latency and the fixed spacing between refreshes, which would reveal an off-by-one in the interval timer. It then runs more than 512 row-only cycles, comparing each driven address with a counter kept in the bench. This catches a wrong increment or a wrong wrap point at 511. Flipping the mode in the middle of a row-only cycle separates sampling at the grant from following the live input. A final stall of ten intervals followed by a grant window checks that exactly `MAX_PEND` postponed refreshes plus the later on-time ones are issued, which distinguishes a saturating counter from one that wraps or counts without limit.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS,
    ST_ADR,
    ST_RAS,
    ST_PRE
  } seq_st_t;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int INTERVAL = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == TW'(INTERVAL - 1));
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_period_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(INTERVAL - 1));

  assert_tick_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int MAX_PEND = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic has_pend_o
);
  localparam int CW = $clog2(MAX_PEND + 1);

  logic [CW-1:0] pend_q, pend_d;
  logic          inc, dec;

  always_comb begin
    inc    = tick_i && (pend_q != CW'(MAX_PEND));
    dec    = take_i && (pend_q != '0);
    pend_d = pend_q;
    if (inc && !dec)      pend_d = pend_q + 1'b1;
    else if (dec && !inc) pend_d = pend_q - 1'b1;
    has_pend_o = (pend_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= CW'(MAX_PEND));

  assert_take_when_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (pend_q != '0));
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int ROWS    = 512,
  parameter int RAS_CYC = 2,
  parameter int PRE_CYC = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_i,
  output logic                    idle_o,
  output logic                    ras_n_o,
  output logic                    cas_n_o,
  output logic [$clog2(ROWS)-1:0] addr_o,
  output logic                    addr_oe_o
);
  localparam int RW   = $clog2(ROWS);
  localparam int PMAX = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
  localparam int PW   = (PMAX > 1) ? $clog2(PMAX) : 1;

  seq_st_t       st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [RW-1:0] row_q, row_d;
  logic          mode_q, mode_d;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    row_d  = row_q;
    mode_d = mode_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        mode_d = mode_i;
        ph_d   = '0;
        st_d   = mode_i ? ST_ADR : ST_CAS;
      end
      ST_CAS, ST_ADR: begin
        ph_d = '0;
        st_d = ST_RAS;
      end
      ST_RAS: if (ph_q == PW'(RAS_CYC - 1)) begin
        ph_d = '0;
        st_d = ST_PRE;
        if (mode_q) row_d = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
      ST_PRE: if (ph_q == PW'(PRE_CYC - 1)) begin
        ph_d = '0;
        st_d = ST_IDLE;
      end else begin
        ph_d = ph_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      row_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      row_q  <= row_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    idle_o    = (st_q == ST_IDLE);
    ras_n_o   = (st_q != ST_RAS);
    cas_n_o   = !((st_q == ST_CAS) || ((st_q == ST_RAS) && !mode_q));
    addr_oe_o = mode_q && ((st_q == ST_ADR) || (st_q == ST_RAS));
    addr_o    = row_q;
  end

  assert_cas_leads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !mode_q) |-> $past(!cas_n_o));

  assert_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && mode_q) |-> ($stable(addr_o) && cas_n_o));

  assert_row_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_q) |-> ((row_q == $past(row_q) + 1'b1) ||
                         (row_q == '0 && $past(row_q) == RW'(ROWS - 1))));

  assert_mode_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && $past(!idle_o)) |-> $stable(mode_q));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int CLK_KHZ   = 250000,
  parameter int WINDOW_US = 8000,
  parameter int ROWS      = 512,
  parameter int MARGIN    = 16,
  parameter int MAX_PEND  = 4,
  parameter int RAS_CYC   = 2,
  parameter int PRE_CYC   = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    row_mode_i,
  input  logic                    gnt_i,
  output logic                    req_o,
  output logic                    ras_n_o,
  output logic                    cas_n_o,
  output logic [$clog2(ROWS)-1:0] addr_o,
  output logic                    addr_oe_o,
  output logic                    dq_oe_o
);
  localparam longint RAW      = (longint'(WINDOW_US) * longint'(CLK_KHZ)) / 64'sd1000 / longint'(ROWS);
  localparam int     INTERVAL = int'(RAW) - MARGIN;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       tick, has_pend, idle, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rfsh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_o (tick)
  );

  rfsh_pending #(.MAX_PEND(MAX_PEND)) u_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .tick_i     (tick),
    .take_i     (start),
    .has_pend_o (has_pend)
  );

  always_comb begin
    req_o   = has_pend && idle;
    start   = req_o && gnt_i;
    dq_oe_o = 1'b0;
  end

  rfsh_seq #(.ROWS(ROWS), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .start_i   (start),
    .mode_i    (row_mode_i),
    .idle_o    (idle),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .addr_o    (addr_o),
    .addr_oe_o (addr_oe_o)
  );

  assert_req_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    req_o |-> (ras_n_o && cas_n_o && !addr_oe_o));

  assert_grant_start_R8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($fell(cas_n_o) || $rose(addr_oe_o)) |-> $past(req_o && gnt_i));
endmodule

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;
  localparam int CLK_KHZ = 1024;
  localparam int MARGIN  = 2;
  localparam int ROWS    = 512;
  localparam int MAXP    = 4;
  localparam int I       = (8000 * CLK_KHZ) / 1000 / ROWS - MARGIN;

  logic       clk = 1'b0;
  logic       rst_n, row_mode, gnt;
  logic       req, ras_n, cas_n, addr_oe, dq_oe;
  logic [8:0] addr;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, nfall = 0, t_last = 0, exp_row = 0;
  bit mon_en = 0, spc_en = 0, have_last = 0, exp_mode = 0, done = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_oe = 1'b0;

  always #2 clk = ~clk;

  rfsh_sched #(.CLK_KHZ(CLK_KHZ), .MARGIN(MARGIN), .ROWS(ROWS), .MAX_PEND(MAXP)) u_rfsh_sched (
    .clk_i(clk), .rst_ni(rst_n), .row_mode_i(row_mode), .gnt_i(gnt),
    .req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_o(addr),
    .addr_oe_o(addr_oe), .dq_oe_o(dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (p_ras && !ras_n) begin
      nfall++;
      if (mon_en) begin
        if (!exp_mode) begin
          chk(p_cas == 1'b0 && cas_n == 1'b0, "R3 cas low before/at ras fall", {p_cas, cas_n}, 0);
          chk(addr_oe == 1'b0, "R3 no address in cbr", addr_oe, 0);
        end else begin
          chk(p_oe && addr_oe, "R4 address enabled around ras fall", {p_oe, addr_oe}, 3);
          chk(cas_n == 1'b1, "R4 cas high in row-only", cas_n, 1);
          chk(int'(addr) == exp_row, "R5 row address sequence", addr, exp_row);
          exp_row = (exp_row + 1) % ROWS;
        end
        if (spc_en && have_last) chk(cyc - t_last == I, "R1 refresh spacing", cyc - t_last, I);
      end
      have_last = 1;
      t_last = cyc;
    end
    if (mon_en) chk(dq_oe == 1'b0, "R6 data lines released", dq_oe, 0);
    p_ras = ras_n; p_cas = cas_n; p_oe = addr_oe;
  end

  task automatic reset_checks();
    chk(ras_n == 1'b1 && cas_n == 1'b1, "R10 strobes idle in reset", {ras_n, cas_n}, 3);
    chk(req == 1'b0, "R10 no request in reset", req, 0);
    chk(addr_oe == 1'b0 && addr == '0, "R10 address idle in reset", {addr_oe, addr}, 0);
    chk(dq_oe == 1'b0, "R6 data lines released in reset", dq_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, base;
    rst_n = 1'b0; gnt = 1'b0; row_mode = 1'b0;
    repeat (3) @(negedge clk);
    reset_checks();

    // R1: first request latency
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 200);
    chk(n == I + 2, "R1 first request latency", n, I + 2);
    chk(ras_n && cas_n && !addr_oe, "R2 bus quiet while requesting", {ras_n, cas_n, addr_oe}, 6);

    // column-before-row under continuous grant
    exp_mode = 0; mon_en = 1; spc_en = 1; have_last = 0;
    gnt = 1'b1;
    while (nfall < 6) @(negedge clk);
    spc_en = 0;

    // row-only sweep across the wrap point
    row_mode = 1'b1; exp_mode = 1;
    while (nfall < 6 + 520) @(negedge clk);

    // R9: flip mode in the middle of a row-only cycle
    do @(negedge clk); while (!(addr_oe && ras_n));
    row_mode = 1'b0;
    @(negedge clk);
    chk(!ras_n && addr_oe && cas_n, "R9 running cycle keeps row-only form", {ras_n, addr_oe, cas_n}, 3);
    @(negedge clk);
    exp_mode = 0;
    base = nfall;
    while (nfall < base + 2) @(negedge clk);

    // R7/R8: stall then drain, after a fresh reset
    gnt = 1'b0; mon_en = 0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    base = nfall;
    repeat (10 * I + 5) @(negedge clk);
    chk(nfall == base, "R8 no refresh without grant", nfall - base, 0);
    chk(req == 1'b1, "R2 request held during stall", req, 1);
    mon_en = 1; exp_mode = 0;
    gnt = 1'b1;
    repeat (10 * I + 7) @(negedge clk);
    gnt = 1'b0;
    repeat (2 * I) @(negedge clk);
    chk(nfall - base == MAXP + 10, "R7 saturated backlog then on-time refreshes", nfall - base, MAXP + 10);
    finish_run();
  end
endmodule